// File: doc/BRIEF.md
# Segmented Bit-Reversed Pulse-Width Modulator

This block drives a single-bit output whose average level, after an external lowpass filter, becomes an analog voltage set by a digital duty code. A free-running counter of `CNT_W` bits defines a frame of 2^CNT_W clock cycles. Before the counter is compared with the duty code, its top `b` bits are rotated down to the least significant end in reversed bit order. The high time of each frame is then split into 2^b sub-pulses of nearly equal width instead of one long pulse, so the ripple left for the filter is 2^b times higher in frequency. Unlike full bit reversal, the number of output edges per frame stays fixed and bounded.

The duty code and the sub-field selector `b` are held in shadow registers and loaded only when the counter wraps. Every frame therefore uses one code and one segmentation. A strobe marks the first cycle of each frame on the output side. The selector is meant to be static, and values above the build-time maximum are clamped.

Top module: `pwmseg_top`

## Requirements
- R1: Output timing. Let k be the frame cycle index, from 0 to 2^CNT_W-1, with k=0 being the cycle in which `frame_o` is high. Write s = k >> (CNT_W-b) and j = k mod 2^(CNT_W-b). Let rev(s) be s with its b bits in reversed order. Then `pwm_o` is high in cycle k exactly when j*2^b + rev(s) < code.
- R2: A frame lasts exactly 2^CNT_W cycles, and `frame_o` is high for exactly one cycle in each frame, in the frame's first cycle.
- R3: The number of cycles in a frame with `pwm_o` high equals the duty code in force for that frame.
- R4: Changes to `duty_i` and `seg_i` have no effect on the frame in progress. They take effect from the first cycle of the next frame.
- R5: A code of 0 keeps `pwm_o` low for the whole frame. The code 2^CNT_W-1 keeps it high for all but one cycle of the frame.
- R6: The duty code d is in the nominal range when 2^b <= d <= 2^CNT_W-2^b. For a code in that range, held over consecutive frames, `pwm_o` makes exactly 2^(b+1) transitions per frame. This count includes the transition into the frame's first cycle.
- R7: Outside the nominal range, the transition count per frame never exceeds 2^(b+1).
- R8: A `seg_i` value greater than `MAX_SEG` behaves exactly like `MAX_SEG`.
- R9: With b = 0 the output is plain PWM: high in the first `code` cycles of the frame and low afterwards.
- R10: While `rst_n` is low, `pwm_o` and `frame_o` are low. The first frame after reset uses code 0, whatever `duty_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_i | input | CNT_W | Duty code; number of high cycles per frame |
| seg_i | input | SEG_W | Sub-field selector b (2^b sub-pulses), clamped to MAX_SEG |
| pwm_o | output | 1 | Registered modulator output |
| frame_o | output | 1 | High in the first cycle of each frame |

## Verification
The hardest situation to reach from the ports is a code change that lands in the middle of a frame. The change must be shown to leave the rest of that frame untouched and to govern the very next frame from its first cycle. The bench changes both the code and the selector partway through a frame. It then compares every cycle of that frame and of the following one against a bench-side slot model. The nominal-range boundaries (codes 2^b and 2^CNT_W-2^b) and the clamped selector are driven directly. Random codes and selectors fill in the rest.

// File: rtl/pwmseg_pkg.sv
package pwmseg_pkg;

  // Move the top b of n count bits to the low end in reversed order,
  // shifting the remaining bits up by b.
  function automatic logic [31:0] remap(input logic [31:0] cnt, input int n, input int b);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) begin
        if (i < b) r[i] = cnt[n-1-i];
        else       r[i] = cnt[i-b];
      end
    end
    return r;
  endfunction

  function automatic int clamp_seg(input int s, input int mx);
    return (s > mx) ? mx : s;
  endfunction

endpackage

// File: rtl/pwmseg_counter.sv
module pwmseg_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/pwmseg_shadow.sv
module pwmseg_shadow #(
  parameter int CNT_W   = 10,
  parameter int MAX_SEG = 4,
  parameter int SEG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [SEG_W-1:0] seg_i,
  output logic [CNT_W-1:0] code_o,
  output logic [SEG_W-1:0] seg_o
);
  logic [CNT_W-1:0] code_q;
  logic [SEG_W-1:0] seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      seg_q  <= '0;
    end else if (load_i) begin
      code_q <= duty_i;
      seg_q  <= SEG_W'(pwmseg_pkg::clamp_seg(int'(seg_i), MAX_SEG));
    end
  end

  assign code_o = code_q;
  assign seg_o  = seg_q;
endmodule

// File: rtl/pwmseg_slicer.sv
module pwmseg_slicer #(
  parameter int CNT_W = 10,
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] code_i,
  input  logic [SEG_W-1:0] seg_i,
  output logic             pwm_o,
  output logic             frame_o
);
  logic [31:0]      remap_full;
  logic [CNT_W-1:0] slot;
  logic             hit;
  logic             pwm_q;
  logic             frame_q;

  always_comb begin
    remap_full = pwmseg_pkg::remap(32'(cnt_i), CNT_W, int'(seg_i));
    slot       = remap_full[CNT_W-1:0];
    hit        = (code_i > slot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      pwm_q   <= hit;
      frame_q <= (cnt_i == '0);
    end
  end

  assign pwm_o   = pwm_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/pwmseg_top.sv
module pwmseg_top #(
  parameter int CNT_W   = 10,
  parameter int MAX_SEG = 4,
  parameter int SEG_W   = $clog2(MAX_SEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [SEG_W-1:0] seg_i,
  output logic             pwm_o,
  output logic             frame_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  logic [CNT_W-1:0] code_q;
  logic [SEG_W-1:0] seg_q;

  pwmseg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt_q), .wrap_o(wrap)
  );

  pwmseg_shadow #(.CNT_W(CNT_W), .MAX_SEG(MAX_SEG), .SEG_W(SEG_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load_i(wrap),
    .duty_i(duty_i), .seg_i(seg_i),
    .code_o(code_q), .seg_o(seg_q)
  );

  pwmseg_slicer #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_slicer (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_q), .code_i(code_q),
    .seg_i(seg_q), .pwm_o(pwm_o), .frame_o(frame_o)
  );
endmodule

// File: rtl/pwmseg_checker.sv
module pwmseg_checker #(
  parameter int CNT_W   = 10,
  parameter int MAX_SEG = 4,
  parameter int SEG_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_o,
  input logic             frame_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] code_q,
  input logic [SEG_W-1:0] seg_q,
  input logic             wrap
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);

  a_r2_strobe_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ##1 frame_o);

  a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(code_q) && $stable(seg_q)));

  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0) |=> !pwm_o);

  a_r8_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(seg_q) <= MAX_SEG);
endmodule

bind pwmseg_top pwmseg_checker #(.CNT_W(CNT_W), .MAX_SEG(MAX_SEG), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .frame_o(frame_o),
  .cnt_q(cnt_q), .code_q(code_q), .seg_q(seg_q), .wrap(wrap)
);

// File: tb/pwmseg_top_test.sv
`timescale 1ns/1ps
module pwmseg_top_test;
  localparam int N     = 10;
  localparam int MSEG  = 4;
  localparam int SW    = 3;
  localparam int FRAME = 1 << N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  duty_i = '0;
  logic [SW-1:0] seg_i = '0;
  logic          pwm_o, frame_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwmseg_top #(.CNT_W(N), .MAX_SEG(MSEG)) uut (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .seg_i(seg_i),
    .pwm_o(pwm_o), .frame_o(frame_o)
  );

  function automatic bit exp_bit(int k, int d, int b);
    int sub, j, rv;
    sub = k >> (N - b);
    j   = k % (1 << (N - b));
    rv  = 0;
    for (int i = 0; i < b; i++) if ((sub >> i) & 1) rv += 1 << (b - 1 - i);
    return (j * (1 << b) + rv) < d;
  endfunction

  function automatic int eff_seg(int s);
    return (s > MSEG) ? MSEG : s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Advance to the negedge where frame_o is high; last = pwm_o one cycle before.
  task automatic to_frame(inout logic last);
    do begin
      last = pwm_o;
      @(negedge clk);
    end while (!frame_o);
  endtask

  task automatic run_code(int d, int s);
    logic last;
    int b, hi, edges, mism, strobes, bound;
    bit nominal;
    @(negedge clk);
    duty_i = N'(d);
    seg_i  = SW'(s);
    last = pwm_o;
    to_frame(last);
    to_frame(last);
    b = eff_seg(s);
    hi = 0; edges = 0; mism = 0; strobes = 0;
    for (int k = 0; k < FRAME; k++) begin
      if (k > 0) @(negedge clk);
      if (frame_o) strobes++;
      if (pwm_o) hi++;
      if (pwm_o != last) edges++;
      if (pwm_o != exp_bit(k, d, b)) mism++;
      last = pwm_o;
    end
    bound   = 1 << (b + 1);
    nominal = (d >= (1 << b)) && (d <= FRAME - (1 << b));
    check(mism == 0, (s > MSEG) ? "R8" : (b == 0 ? "R9" : "R1"), "per-cycle mismatches", mism, 0);
    check(hi == d, "R3", "high cycles", hi, d);
    check(strobes == 1, "R2", "strobes per frame", strobes, 1);
    if (nominal) check(edges == bound, "R6", "transitions", edges, bound);
    else         check(edges <= bound, "R7", "transitions bound", edges, bound);
    if (d == 0)         check(hi == 0, "R5", "zero code high", hi, 0);
    if (d == FRAME - 1) check(hi == FRAME - 1, "R5", "max code high", hi, FRAME - 1);
  endtask

  task automatic shadow_test(int d1, int s1, int d2, int s2);
    logic last;
    int mism_old, mism_new, fs;
    run_code(d1, s1);
    mism_old = 0; mism_new = 0; fs = 0;
    for (int k = 0; k < 2 * FRAME; k++) begin
      @(negedge clk);
      if (k == 0 || k == FRAME) fs += frame_o ? 1 : 0;
      if (k < FRAME) begin
        if (pwm_o != exp_bit(k, d1, eff_seg(s1))) mism_old++;
      end else begin
        if (pwm_o != exp_bit(k - FRAME, d2, eff_seg(s2))) mism_new++;
      end
      if (k == 400) begin
        duty_i = N'(d2);
        seg_i  = SW'(s2);
      end
    end
    check(mism_old == 0, "R4", "mid-frame change leaked", mism_old, 0);
    check(mism_new == 0, "R4", "next frame new code", mism_new, 0);
    check(fs == 2, "R2", "strobes at frame starts", fs, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi, sd;
    logic last;
    sd = int'($urandom(32'd2024));
    duty_i = N'(555);
    seg_i  = SW'(2);
    repeat (3) @(negedge clk);
    check(pwm_o == 1'b0, "R10", "pwm in reset", int'(pwm_o), 0);
    check(frame_o == 1'b0, "R10", "strobe in reset", int'(frame_o), 0);
    rst_n = 1'b1;
    last = 1'b0;
    to_frame(last);
    hi = 0;
    for (int k = 0; k < FRAME; k++) begin
      if (k > 0) @(negedge clk);
      if (pwm_o) hi++;
    end
    check(hi == 0, "R10", "first frame high cycles", hi, 0);

    run_code(0, 3);
    run_code(FRAME - 1, 3);
    run_code(1, 3);
    run_code(8, 3);
    run_code(FRAME - 8, 3);
    run_code(16, 4);
    run_code(FRAME - 16, 4);
    run_code(512, 0);
    run_code(1, 0);
    run_code(300, 7);
    run_code(700, 5);
    run_code(FRAME - 3, 2);
    shadow_test(200, 1, 777, 4);

    for (int t = 0; t < 18; t++) begin
      run_code(int'($urandom % FRAME), int'($urandom % 8));
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule